// File: doc/BRIEF.md
# Configuration Completion Receiver

This block waits for the answer to a configuration access that has already been sent. It takes in a 64-bit completion stream in which each beat carries a start-of-packet flag and an end-of-packet flag. The first beat of a packet carries a three-bit completion status. The last beat carries the returned dword in its lower 32 bits. The block reports done with either success or failure. On a successful read it narrows the returned dword to the requested byte or halfword. If no packet end arrives within a bounded window, it gives up and reports failure.

A request is started by a one-cycle pulse that also describes the target. If the target cannot exist, the block answers at once without waiting. This covers any slot other than zero on the root bus, and any non-root bus while the link is down. The result flags and the data stay on the outputs until the next accepted request. The timeout window is set by two parameters: a poll interval in clock cycles, and the number of intervals, which defaults to 500.

Top module: `cfg_cpl_rx`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `tmo_o` are low and `rdata_o` is zero.
- R2: The completion status is `cpl_data[46:44]`, which is bits [14:12] of the upper dword of the start beat. It is captured when a start beat is taken. Any nonzero status makes the result a failure.
- R3: An accepted end beat ends the wait. On the following cycle `done_o` is high and `busy_o` is low. On success `rdata_o` comes from `cpl_data[31:0]` of that end beat. When one beat carries both start and end, that beat's own status decides the result.
- R4: While waiting, and before any start beat has been taken, a valid beat with neither flag set is discarded. The block stays busy, and the beat's contents play no part in the result.
- R5: An end beat that arrives with no start beat before it gives a failure, because the status defaults to a nonzero value.
- R6: Size code 2'b00 is a byte read. Its result is the dword shifted right by 8×`req_off`, masked to 8 bits. Code 2'b01 is a halfword read. Its result is the dword shifted right by 16×`req_off[1]`, masked to 16 bits. Codes 2'b10 and 2'b11 return the whole dword.
- R7: Every failed result drives `rdata_o` to all ones.
- R8: An invalid target answers on the cycle after the start pulse with `done_o` and `err_o` high, and the block does not wait. A target is invalid when it is on the root bus (`req_root`=1) with a nonzero slot, or on a non-root bus while `link_up` is low.
- R9: If no end beat is taken within POLL_CYC×MAX_POLLS clock edges after the start edge, the block reports `done_o`, `err_o` and `tmo_o` together. It stays busy up to that point.
- R10: An end beat taken on the final edge of the window wins over the timeout. The result is then judged only by the completion status, and `tmo_o` stays low.
- R11: A start pulse while `busy_o` is high is ignored.
- R12: An accepted start clears `done_o`, `err_o` and `tmo_o`. Otherwise the flags and `rdata_o` hold their values while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start | input | 1 | One-cycle pulse that starts a request |
| req_root | input | 1 | Target is on the root bus |
| req_slot | input | SLOT_W | Target slot number |
| link_up | input | 1 | Link is trained and usable |
| req_size | input | 2 | Access size code (see R6) |
| req_off | input | OFF_W | Byte offset inside the dword |
| cpl_valid | input | 1 | Completion beat is present |
| cpl_sop | input | 1 | Beat is the first of a packet |
| cpl_eop | input | 1 | Beat is the last of a packet |
| cpl_data | input | BEAT_W | Beat payload |
| busy_o | output | 1 | Waiting for a completion |
| done_o | output | 1 | Result is available |
| err_o | output | 1 | Result is a failure (device not found) |
| tmo_o | output | 1 | Failure was caused by the timeout |
| rdata_o | output | DW_W | Returned data, narrowed to the access size |

## Verification
Two events can fall in the same cycle: an end beat arriving and the timeout window expiring. The bench provokes this by idling for exactly one edge fewer than the window, then presenting a combined start-and-end beat with zero status on the final edge. It expects success with `tmo_o` low. A second pair is also exercised. A start pulse is issued while a wait is still in progress and must be ignored, and a later beat must still complete the original request with the original size and offset. A behavioural model compares every output on every cycle.

// File: rtl/cplrx_pkg.sv
package cplrx_pkg;
   typedef enum logic {ST_IDLE, ST_WAIT} cplrx_st_e;
   localparam logic [1:0] SZ_BYTE = 2'b00;
   localparam logic [1:0] SZ_HALF = 2'b01;
endpackage

// File: rtl/cplrx_devchk.sv
module cplrx_devchk #(
   parameter int SLOT_W = 5
) (
   input  logic              on_root,
   input  logic [SLOT_W-1:0] slot,
   input  logic              link_up,
   output logic              dev_ok
);
   // only one slot exists below the root; remote buses need a live link
   always_comb begin
      if (on_root) dev_ok = (slot == '0);
      else         dev_ok = link_up;
   end
endmodule

// File: rtl/cplrx_lane.sv
module cplrx_lane #(
   parameter int DW_W = 32
) (
   input  logic [DW_W-1:0]                 dw,
   input  logic [1:0]                      size,
   input  logic [$clog2(DW_W/8)-1:0]       off,
   output logic [DW_W-1:0]                 narrowed
);
   import cplrx_pkg::*;
   localparam int OFF_W = $clog2(DW_W/8);

   logic [DW_W-1:0] byte_sh;
   logic [DW_W-1:0] half_sh;

   always_comb begin
      byte_sh = dw >> (8 * off);
      half_sh = dw >> (16 * off[OFF_W-1]);
      case (size)
         SZ_BYTE: narrowed = {{(DW_W-8){1'b0}},  byte_sh[7:0]};
         SZ_HALF: narrowed = {{(DW_W-16){1'b0}}, half_sh[15:0]};
         default: narrowed = dw;
      endcase
   end
endmodule

// File: rtl/cplrx_window.sv
module cplrx_window #(
   parameter int POLL_CYC  = 4,
   parameter int MAX_POLLS = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expire
);
   localparam int POLL_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
   localparam logic [POLL_W-1:0] LAST_P = POLL_W'(MAX_POLLS - 1);

   logic [POLL_W-1:0] poll_q;
   logic              tick_last;

   generate
      if (POLL_CYC == 1) begin : g_flat
         assign tick_last = 1'b1;
      end else begin : g_tick
         localparam int TICK_W = $clog2(POLL_CYC);
         localparam logic [TICK_W-1:0] LAST_T = TICK_W'(POLL_CYC - 1);
         logic [TICK_W-1:0] tick_q;
         assign tick_last = (tick_q == LAST_T);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                tick_q <= '0;
            else if (clear)            tick_q <= '0;
            else if (run && !expire)   tick_q <= tick_last ? '0 : tick_q + 1'b1;
         end
      end
   endgenerate

   assign expire = run && tick_last && (poll_q == LAST_P);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           poll_q <= '0;
      else if (clear)                       poll_q <= '0;
      else if (run && !expire && tick_last) poll_q <= poll_q + 1'b1;
   end
endmodule

// File: rtl/cfg_cpl_rx.sv
module cfg_cpl_rx #(
   parameter int BEAT_W    = 64,
   parameter int DW_W      = 32,
   parameter int STAT_LSB  = 12,
   parameter int STAT_W    = 3,
   parameter int SLOT_W    = 5,
   parameter int POLL_CYC  = 4,
   parameter int MAX_POLLS = 500,
   parameter int OFF_W     = $clog2(DW_W/8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic              req_root,
   input  logic [SLOT_W-1:0] req_slot,
   input  logic              link_up,
   input  logic [1:0]        req_size,
   input  logic [OFF_W-1:0]  req_off,
   input  logic              cpl_valid,
   input  logic              cpl_sop,
   input  logic              cpl_eop,
   input  logic [BEAT_W-1:0] cpl_data,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic              tmo_o,
   output logic [DW_W-1:0]   rdata_o
);
   import cplrx_pkg::*;

   localparam int STAT_POS = DW_W + STAT_LSB;
   localparam logic [STAT_W-1:0] STAT_DEF = '1;

   generate
      if (BEAT_W != 2 * DW_W) begin : g_bad_beat
         $error("cfg_cpl_rx: BEAT_W must be twice DW_W");
      end
      if (STAT_LSB + STAT_W > DW_W) begin : g_bad_stat
         $error("cfg_cpl_rx: status field exceeds upper dword");
      end
      if (POLL_CYC < 1 || MAX_POLLS < 2) begin : g_bad_win
         $error("cfg_cpl_rx: window parameters out of range");
      end
      if (OFF_W != $clog2(DW_W/8)) begin : g_bad_off
         $error("cfg_cpl_rx: OFF_W must match DW_W");
      end
   endgenerate

   cplrx_st_e         st_q;
   logic              sop_seen_q;
   logic [STAT_W-1:0] stat_q;
   logic [1:0]        size_q;
   logic [OFF_W-1:0]  off_q;

   logic              dev_ok;
   logic              accept;
   logic              waiting;
   logic              take;
   logic              fin_eop;
   logic              expire;
   logic [STAT_W-1:0] beat_stat;
   logic [STAT_W-1:0] eff_stat;
   logic [DW_W-1:0]   narrowed;

   cplrx_devchk #(.SLOT_W(SLOT_W)) u_devchk (
      .on_root (req_root),
      .slot    (req_slot),
      .link_up (link_up),
      .dev_ok  (dev_ok)
   );

   cplrx_lane #(.DW_W(DW_W)) u_lane (
      .dw       (cpl_data[DW_W-1:0]),
      .size     (size_q),
      .off      (off_q),
      .narrowed (narrowed)
   );

   cplrx_window #(.POLL_CYC(POLL_CYC), .MAX_POLLS(MAX_POLLS)) u_window (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (accept),
      .run    (waiting),
      .expire (expire)
   );

   assign waiting   = (st_q == ST_WAIT);
   assign accept    = req_start && !waiting;
   assign take      = waiting && cpl_valid && (cpl_sop || cpl_eop || sop_seen_q);
   assign fin_eop   = take && cpl_eop;
   assign beat_stat = cpl_data[STAT_POS +: STAT_W];
   assign eff_stat  = cpl_sop ? beat_stat : stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         sop_seen_q <= 1'b0;
         stat_q     <= STAT_DEF;
         size_q     <= '0;
         off_q      <= '0;
         done_o     <= 1'b0;
         err_o      <= 1'b0;
         tmo_o      <= 1'b0;
         rdata_o    <= '0;
      end else if (accept) begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         tmo_o  <= 1'b0;
         if (!dev_ok) begin
            done_o  <= 1'b1;
            err_o   <= 1'b1;
            rdata_o <= '1;
         end else begin
            st_q       <= ST_WAIT;
            sop_seen_q <= 1'b0;
            stat_q     <= STAT_DEF;
            size_q     <= req_size;
            off_q      <= req_off;
         end
      end else if (waiting) begin
         if (take && cpl_sop) begin
            sop_seen_q <= 1'b1;
            stat_q     <= beat_stat;
         end
         if (fin_eop) begin
            st_q    <= ST_IDLE;
            done_o  <= 1'b1;
            err_o   <= (eff_stat != '0);
            rdata_o <= (eff_stat != '0) ? '1 : narrowed;
         end else if (expire) begin
            st_q    <= ST_IDLE;
            done_o  <= 1'b1;
            err_o   <= 1'b1;
            tmo_o   <= 1'b1;
            rdata_o <= '1;
         end
      end
   end

   assign busy_o = waiting;
endmodule

// File: rtl/cfg_cpl_rx_chk.sv
module cfg_cpl_rx_chk #(
   parameter int SLOT_W = 5,
   parameter int DW_W   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_start,
   input logic              req_root,
   input logic [SLOT_W-1:0] req_slot,
   input logic              cpl_valid,
   input logic              cpl_eop,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o,
   input logic              tmo_o,
   input logic [DW_W-1:0]   rdata_o
);
   // R3
   eop_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && cpl_valid && cpl_eop |=> done_o && !busy_o);

   // R7
   fail_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && err_o |-> rdata_o == '1);

   // R8
   bad_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && req_start && req_root && (req_slot != '0) |=> done_o && err_o && !busy_o);

   // R9
   tmo_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_o |-> done_o && err_o);

   // R12
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && !req_start |=> $stable(done_o) && $stable(err_o) && $stable(rdata_o));

   // R11
   busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !cpl_valid |=> busy_o || tmo_o);

   // R3
   excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && busy_o));
endmodule

bind cfg_cpl_rx cfg_cpl_rx_chk #(.SLOT_W(SLOT_W), .DW_W(DW_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_start (req_start),
   .req_root  (req_root),
   .req_slot  (req_slot),
   .cpl_valid (cpl_valid),
   .cpl_eop   (cpl_eop),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .err_o     (err_o),
   .tmo_o     (tmo_o),
   .rdata_o   (rdata_o)
);

// File: tb/cfg_cpl_rx_tb.sv
module cfg_cpl_rx_tb;
   localparam int PC  = 4;
   localparam int MP  = 500;
   localparam int WIN = PC * MP;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_start = 1'b0;
   logic        req_root = 1'b0;
   logic [4:0]  req_slot = '0;
   logic        link_up = 1'b0;
   logic [1:0]  req_size = '0;
   logic [1:0]  req_off = '0;
   logic        cpl_valid = 1'b0;
   logic        cpl_sop = 1'b0;
   logic        cpl_eop = 1'b0;
   logic [63:0] cpl_data = '0;
   logic        busy_o, done_o, err_o, tmo_o;
   logic [31:0] rdata_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   cfg_cpl_rx #(.POLL_CYC(PC), .MAX_POLLS(MP)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_root(req_root),
      .req_slot(req_slot), .link_up(link_up), .req_size(req_size), .req_off(req_off),
      .cpl_valid(cpl_valid), .cpl_sop(cpl_sop), .cpl_eop(cpl_eop), .cpl_data(cpl_data),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .tmo_o(tmo_o), .rdata_o(rdata_o)
   );

   // behavioural reference
   bit          m_busy, m_done, m_err, m_tmo, m_sop;
   int          m_cnt;
   int unsigned m_stat;
   logic [31:0] m_rdata;
   logic [1:0]  m_size, m_off;

   function automatic logic [31:0] narrow(logic [31:0] d, logic [1:0] sz, logic [1:0] off);
      if (sz == 2'b00) return (d >> (8 * off)) & 32'hff;
      if (sz == 2'b01) return (d >> (off[1] ? 16 : 0)) & 32'hffff;
      return d;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_err = 0; m_tmo = 0; m_sop = 0;
         m_cnt = 0; m_stat = 7; m_rdata = '0; m_size = '0; m_off = '0;
      end else if (m_busy) begin
         if (cpl_valid && (cpl_sop || cpl_eop || m_sop)) begin
            if (cpl_sop) begin m_sop = 1; m_stat = int'(cpl_data[46:44]); end
         end
         if (cpl_valid && cpl_eop) begin
            m_busy = 0; m_done = 1; m_err = (m_stat != 0);
            m_rdata = m_err ? 32'hffffffff : narrow(cpl_data[31:0], m_size, m_off);
         end else if (m_cnt == WIN - 1) begin
            m_busy = 0; m_done = 1; m_err = 1; m_tmo = 1; m_rdata = 32'hffffffff;
         end else m_cnt++;
      end else if (req_start) begin
         m_done = 0; m_err = 0; m_tmo = 0;
         if (req_root ? (req_slot != 0) : !link_up) begin
            m_done = 1; m_err = 1; m_rdata = 32'hffffffff;
         end else begin
            m_busy = 1; m_sop = 0; m_stat = 7; m_cnt = 0; m_size = req_size; m_off = req_off;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if ({busy_o, done_o, err_o, tmo_o} !== {m_busy, m_done, m_err, m_tmo} || rdata_o !== m_rdata) begin
            errors++;
            $display("FAIL model t=%0t act b%0b d%0b e%0b t%0b %h exp b%0b d%0b e%0b t%0b %h", $time,
                     busy_o, done_o, err_o, tmo_o, rdata_o, m_busy, m_done, m_err, m_tmo, m_rdata);
         end
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic req(bit root, logic [4:0] slot, bit link, logic [1:0] sz, logic [1:0] off);
      req_start = 1; req_root = root; req_slot = slot; link_up = link; req_size = sz; req_off = off;
      @(negedge clk);
      req_start = 0;
   endtask

   task automatic beat(bit sop, bit eop, logic [2:0] st, logic [31:0] lo);
      cpl_valid = 1; cpl_sop = sop; cpl_eop = eop;
      cpl_data = {17'h1abcd, st, 12'h5a5, lo};
      @(negedge clk);
      cpl_valid = 0; cpl_sop = 0; cpl_eop = 0; cpl_data = '0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // {busy,done,err,tmo}
   function automatic logic [31:0] fl();
      return {28'd0, busy_o, done_o, err_o, tmo_o};
   endfunction

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 flags", fl(), 32'h0);
      check("R1 rdata", rdata_o, 32'h0);
      rst_n = 1;
      @(negedge clk);

      // R2 R3 dword success, two-beat packet
      req(1, 0, 0, 2'b10, 0);
      check("R3 busy", fl(), 32'h8);
      beat(1, 0, 3'd0, 32'h0);
      beat(0, 1, 3'd0, 32'hcafebabe);
      check("R3 flags", fl(), 32'h4);
      check("R3 data", rdata_o, 32'hcafebabe);
      idle(3);
      check("R12 hold", rdata_o, 32'hcafebabe);

      // R2 nonzero status
      req(1, 0, 0, 2'b10, 0);
      beat(1, 0, 3'd2, 32'h0);
      beat(0, 1, 3'd0, 32'h12345678);
      check("R2 flags", fl(), 32'h6);
      check("R7 ones", rdata_o, 32'hffffffff);

      // R3 single beat, status from that beat
      req(0, 3, 1, 2'b10, 0);
      beat(1, 1, 3'd0, 32'h0badf00d);
      check("R3 same-beat", fl(), 32'h4);
      check("R3 same-beat data", rdata_o, 32'h0badf00d);

      // R4 unflagged beat before SOP discarded, then real packet
      req(1, 0, 0, 2'b10, 0);
      beat(0, 0, 3'd0, 32'hdeadbeef);
      check("R4 still busy", fl(), 32'h8);
      beat(1, 0, 3'd0, 32'h0);
      beat(0, 0, 3'd0, 32'h11111111);
      beat(0, 1, 3'd0, 32'h76543210);
      check("R4 data", rdata_o, 32'h76543210);
      check("R4 flags", fl(), 32'h4);

      // R5 EOP without SOP
      req(1, 0, 0, 2'b10, 0);
      beat(0, 1, 3'd0, 32'h22222222);
      check("R5 flags", fl(), 32'h6);

      // R6 byte and halfword lanes
      for (int o = 0; o < 4; o++) begin
         req(1, 0, 0, 2'b00, 2'(o));
         beat(1, 1, 3'd0, 32'h44332211);
         check("R6 byte", rdata_o, 32'h11 * (o + 1));
      end
      req(1, 0, 0, 2'b01, 2'd0);
      beat(1, 1, 3'd0, 32'h44332211);
      check("R6 half lo", rdata_o, 32'h2211);
      req(1, 0, 0, 2'b01, 2'd3);
      beat(1, 1, 3'd0, 32'h44332211);
      check("R6 half hi", rdata_o, 32'h4433);

      // R8 invalid targets
      req(1, 2, 1, 2'b10, 0);
      check("R8 root slot", fl(), 32'h6);
      check("R8 ones", rdata_o, 32'hffffffff);
      req(0, 0, 0, 2'b10, 0);
      check("R8 link down", fl(), 32'h6);

      // R11 start while busy ignored; original size used
      req(1, 0, 0, 2'b00, 2'd1);
      req(1, 5, 0, 2'b10, 0);
      check("R11 busy", fl(), 32'h8);
      beat(1, 1, 3'd0, 32'haabbccdd);
      check("R11 result", rdata_o, 32'h000000cc);

      // R9 timeout
      req(1, 0, 0, 2'b10, 0);
      check("R12 clear", fl(), 32'h8);
      idle(WIN - 1);
      check("R9 not early", fl(), 32'h8);
      idle(1);
      check("R9 timeout", fl(), 32'h7);
      check("R9 ones", rdata_o, 32'hffffffff);

      // R10 EOP on final window edge
      req(1, 0, 0, 2'b10, 0);
      idle(WIN - 1);
      beat(1, 1, 3'd0, 32'h600df00d);
      check("R10 flags", fl(), 32'h4);
      check("R10 data", rdata_o, 32'h600df00d);

      idle(4);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule